// File: doc/BRIEF.md
# Pipeline Hazard Resolver

This block is the purely combinational hazard logic of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) whose branches are resolved in decode. It looks at the register numbers that the decode and execute stages read. It also looks at the destination numbers and write enables of the instructions ahead of them in execute, memory and writeback. From these it chooses the bypass paths for the two ALU operands and for the two inputs of the decode-stage equality comparator.

When a bypass cannot supply a value in time, the block holds the front of the pipeline and inserts a bubble into execute. That happens when a load feeds the very next instruction, and when a branch needs a result that is still being computed or still being loaded. When a branch resolves as taken and nothing holds it, the block also clears the wrongly fetched instruction in decode. Pipeline registers, the comparator and the datapath multiplexers sit outside the block.

Top module: `hazard_resolver`

## Requirements
- R1: `fwd_a_e` is 2'b10 (memory result) when `rs_e` is nonzero, equals `dst_m` and `wr_en_m` is high. Otherwise it is 2'b01 (writeback result) when `rs_e` is nonzero, equals `dst_w` and `wr_en_w` is high. In every other case it is 2'b00 (register file value), so the memory stage wins when both stages match.
- R2: `fwd_b_e` follows the same encoding and priority as R1, with `rt_e` as the source.
- R3: A source register number of zero never produces a bypass, neither in execute nor in decode, whatever the destinations and write enables are.
- R4: A load-use hazard exists when `load_e` is high and `rt_e` equals `rs_d` or `rt_d`.
- R5: `fwd_a_d` (or `fwd_b_d`) is 1 exactly when `rs_d` (or `rt_d`) is nonzero, equals `dst_m` and `wr_en_m` is high.
- R6: A branch hazard exists when `branch_d` is high, `wr_en_e` is high and `dst_e` equals `rs_d` or `rt_d`.
- R7: A branch hazard also exists when `branch_d` is high, `load_m` is high and `dst_m` equals `rs_d` or `rt_d`. A memory-stage match with `wr_en_m` high but `load_m` low does not stall.
- R8: `stall_f`, `stall_d` and `flush_e` are all equal to the OR of the load-use hazard and the branch hazard. Without `branch_d`, the two branch conditions have no effect on them.
- R9: `flush_d` is 1 exactly when `branch_d` and `br_eq_d` are high and the stall of R8 is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rs_d | input | REG_W | first source register in decode |
| rt_d | input | REG_W | second source register in decode |
| rs_e | input | REG_W | first source register in execute |
| rt_e | input | REG_W | second source register in execute (load destination) |
| dst_e | input | REG_W | destination register in execute |
| dst_m | input | REG_W | destination register in memory |
| dst_w | input | REG_W | destination register in writeback |
| wr_en_e | input | 1 | execute instruction writes a register |
| wr_en_m | input | 1 | memory instruction writes a register |
| wr_en_w | input | 1 | writeback instruction writes a register |
| load_e | input | 1 | execute instruction is a load |
| load_m | input | 1 | memory instruction is a load |
| branch_d | input | 1 | decode instruction is a conditional branch |
| br_eq_d | input | 1 | decode comparator reports equal operands |
| fwd_a_e | output | 2 | ALU operand A source select |
| fwd_b_e | output | 2 | ALU operand B source select |
| fwd_a_d | output | 1 | comparator input A takes the memory result |
| fwd_b_d | output | 1 | comparator input B takes the memory result |
| stall_f | output | 1 | hold the fetch stage |
| stall_d | output | 1 | hold the decode stage |
| flush_e | output | 1 | clear the execute stage |
| flush_d | output | 1 | clear the decode stage after a taken branch |

## Verification
No register lies between any input and any output, so every result is due in the same cycle as the stimulus that causes it. The bench changes inputs only on the falling clock edge. It samples all outputs a quarter period later, well before the next rising edge, so each comparison sees settled values from exactly one input pattern. A table of patterns covers forwarding priority, load-use and both branch-hazard sources. Directed sweeps then cover the zero register and the false stall cases.

// File: rtl/hazard_resolver.sv
module hazard_resolver #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] rs_d,
  input  logic [REG_W-1:0] rt_d,
  input  logic [REG_W-1:0] rs_e,
  input  logic [REG_W-1:0] rt_e,
  input  logic [REG_W-1:0] dst_e,
  input  logic [REG_W-1:0] dst_m,
  input  logic [REG_W-1:0] dst_w,
  input  logic             wr_en_e,
  input  logic             wr_en_m,
  input  logic             wr_en_w,
  input  logic             load_e,
  input  logic             load_m,
  input  logic             branch_d,
  input  logic             br_eq_d,
  output logic [1:0]       fwd_a_e,
  output logic [1:0]       fwd_b_e,
  output logic             fwd_a_d,
  output logic             fwd_b_d,
  output logic             stall_f,
  output logic             stall_d,
  output logic             flush_e,
  output logic             flush_d
);

  localparam logic [REG_W-1:0] ZERO_REG = '0;
  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_WB  = 2'b01;
  localparam logic [1:0] SEL_MEM = 2'b10;

  function automatic logic hit(input logic [REG_W-1:0] src,
                               input logic [REG_W-1:0] dst,
                               input logic en);
    return en && (src != ZERO_REG) && (src == dst);
  endfunction

  function automatic logic [1:0] ex_sel(input logic [REG_W-1:0] src);
    if (hit(src, dst_m, wr_en_m))      return SEL_MEM;
    else if (hit(src, dst_w, wr_en_w)) return SEL_WB;
    else                               return SEL_RF;
  endfunction

  logic load_use, br_hold, hold;

  assign fwd_a_e = ex_sel(rs_e);
  assign fwd_b_e = ex_sel(rt_e);
  assign fwd_a_d = hit(rs_d, dst_m, wr_en_m);
  assign fwd_b_d = hit(rt_d, dst_m, wr_en_m);

  assign load_use = load_e && ((rt_e == rs_d) || (rt_e == rt_d));
  assign br_hold  = branch_d &&
                    ((wr_en_e && ((dst_e == rs_d) || (dst_e == rt_d))) ||
                     (load_m  && ((dst_m == rs_d) || (dst_m == rt_d))));
  assign hold     = load_use || br_hold;

  assign stall_f = hold;
  assign stall_d = hold;
  assign flush_e = hold;
  assign flush_d = branch_d && br_eq_d && !hold;

  always_comb begin
    a_r1_sel_a_legal: assert (fwd_a_e != 2'b11)
      else $error("R1 operand A select uses the unused code");
    a_r2_sel_b_legal: assert (fwd_b_e != 2'b11)
      else $error("R2 operand B select uses the unused code");
    a_r3_zero_no_bypass: assert (!((rs_e == ZERO_REG && fwd_a_e != SEL_RF) ||
                                   (rt_e == ZERO_REG && fwd_b_e != SEL_RF) ||
                                   (rs_d == ZERO_REG && fwd_a_d) ||
                                   (rt_d == ZERO_REG && fwd_b_d)))
      else $error("R3 register zero was bypassed");
    a_r5_dec_fwd_needs_mem_write: assert (!((fwd_a_d || fwd_b_d) && !wr_en_m))
      else $error("R5 decode bypass without a memory-stage write");
    a_r8_stall_has_cause: assert (!(stall_f && !load_e && !branch_d))
      else $error("R8 stall raised with neither a load nor a branch");
    a_r9_flush_excludes_stall: assert (!(flush_d && (stall_d || !branch_d)))
      else $error("R9 decode flush while stalled or without a branch");
  end

endmodule

// File: tb/test_hazard_resolver.sv
module test_hazard_resolver;

  localparam int CLK_PERIOD = 10;
  localparam int W = 5;
  localparam int N_VEC = 15;

  typedef struct packed {
    logic [W-1:0] rsd, rtd, rse, rte, dse, dsm, dsw;
    logic we_e, we_m, we_w, ld_e, ld_m, br, eq;
    logic [1:0] xa, xb;
    logic da, db, st, fd;
  } vec_t;

  // fields: rsd rtd rse rte dse dsm dsw | we_e we_m we_w ld_e ld_m br eq | xa xb da db st fd
  localparam vec_t TBL [N_VEC] = '{
    '{5'd0,5'd0,5'd0,5'd0,5'd0,5'd0,5'd0,   1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 2'b00,2'b00,1'b0,1'b0,1'b0,1'b0}, // idle
    '{5'd1,5'd2,5'd3,5'd4,5'd9,5'd3,5'd10,  1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 2'b10,2'b00,1'b0,1'b0,1'b0,1'b0}, // R1 memory bypass
    '{5'd1,5'd2,5'd6,5'd5,5'd9,5'd7,5'd5,   1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 2'b00,2'b01,1'b0,1'b0,1'b0,1'b0}, // R2 writeback bypass
    '{5'd1,5'd2,5'd8,5'd8,5'd9,5'd8,5'd8,   1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 2'b10,2'b10,1'b0,1'b0,1'b0,1'b0}, // R1 R2 priority
    '{5'd1,5'd2,5'd8,5'd3,5'd9,5'd8,5'd8,   1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 2'b01,2'b00,1'b0,1'b0,1'b0,1'b0}, // R1 memory not writing
    '{5'd0,5'd0,5'd0,5'd0,5'd9,5'd0,5'd0,   1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 2'b00,2'b00,1'b0,1'b0,1'b0,1'b0}, // R3 zero register
    '{5'd4,5'd2,5'd1,5'd4,5'd4,5'd9,5'd10,  1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 2'b00,2'b00,1'b0,1'b0,1'b1,1'b0}, // R4 load-use on rs_d
    '{5'd1,5'd4,5'd3,5'd4,5'd4,5'd9,5'd10,  1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 2'b00,2'b00,1'b0,1'b0,1'b1,1'b0}, // R4 load-use on rt_d
    '{5'd1,5'd2,5'd3,5'd4,5'd4,5'd9,5'd10,  1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 2'b00,2'b00,1'b0,1'b0,1'b0,1'b0}, // R4 load, no use
    '{5'd6,5'd6,5'd1,5'd2,5'd9,5'd6,5'd10,  1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1, 2'b00,2'b00,1'b1,1'b1,1'b0,1'b1}, // R5 R9 bypassed taken branch
    '{5'd1,5'd7,5'd3,5'd2,5'd7,5'd9,5'd10,  1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 2'b00,2'b00,1'b0,1'b0,1'b1,1'b0}, // R6 branch on ALU result
    '{5'd5,5'd2,5'd1,5'd3,5'd9,5'd5,5'd10,  1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0, 2'b00,2'b00,1'b1,1'b0,1'b1,1'b0}, // R7 branch on load
    '{5'd7,5'd2,5'd1,5'd2,5'd7,5'd9,5'd10,  1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 2'b00,2'b00,1'b0,1'b0,1'b0,1'b0}, // R8 no branch
    '{5'd1,5'd2,5'd3,5'd4,5'd9,5'd10,5'd11, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 2'b00,2'b00,1'b0,1'b0,1'b0,1'b0}, // R9 not taken
    '{5'd1,5'd2,5'd3,5'd4,5'd9,5'd10,5'd11, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 2'b00,2'b00,1'b0,1'b0,1'b0,1'b1}  // R9 taken
  };

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [W-1:0] rs_d, rt_d, rs_e, rt_e, dst_e, dst_m, dst_w;
  logic wr_en_e, wr_en_m, wr_en_w, load_e, load_m, branch_d, br_eq_d;
  logic [1:0] fwd_a_e, fwd_b_e;
  logic fwd_a_d, fwd_b_d, stall_f, stall_d, flush_e, flush_d;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  hazard_resolver #(.REG_W(W)) i_hazard_resolver (
    .rs_d(rs_d), .rt_d(rt_d), .rs_e(rs_e), .rt_e(rt_e),
    .dst_e(dst_e), .dst_m(dst_m), .dst_w(dst_w),
    .wr_en_e(wr_en_e), .wr_en_m(wr_en_m), .wr_en_w(wr_en_w),
    .load_e(load_e), .load_m(load_m), .branch_d(branch_d), .br_eq_d(br_eq_d),
    .fwd_a_e(fwd_a_e), .fwd_b_e(fwd_b_e), .fwd_a_d(fwd_a_d), .fwd_b_d(fwd_b_d),
    .stall_f(stall_f), .stall_d(stall_d), .flush_e(flush_e), .flush_d(flush_d)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    {rs_d, rt_d, rs_e, rt_e, dst_e, dst_m, dst_w} = {v.rsd, v.rtd, v.rse, v.rte, v.dse, v.dsm, v.dsw};
    {wr_en_e, wr_en_m, wr_en_w, load_e, load_m, branch_d, br_eq_d} =
      {v.we_e, v.we_m, v.we_w, v.ld_e, v.ld_m, v.br, v.eq};
    #(CLK_PERIOD/4);
  endtask

  task automatic check_stall(input string req, input logic exp);
    chk(req, "stall_f", int'(stall_f), int'(exp));
    chk(req, "stall_d", int'(stall_d), int'(exp));
    chk(req, "flush_e", int'(flush_e), int'(exp));
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    vec_t v;
    // idle state: all-zero inputs give no bypass and no stall
    drive('0);
    chk("R1", "idle fwd_a_e", int'(fwd_a_e), 0);
    chk("R8", "idle stall_f", int'(stall_f), 0);

    for (int i = 0; i < N_VEC; i++) begin
      drive(TBL[i]);
      chk("R1", $sformatf("vec%0d fwd_a_e", i), int'(fwd_a_e), int'(TBL[i].xa));
      chk("R2", $sformatf("vec%0d fwd_b_e", i), int'(fwd_b_e), int'(TBL[i].xb));
      chk("R5", $sformatf("vec%0d fwd_a_d", i), int'(fwd_a_d), int'(TBL[i].da));
      chk("R5", $sformatf("vec%0d fwd_b_d", i), int'(fwd_b_d), int'(TBL[i].db));
      check_stall("R8", TBL[i].st);
      chk("R9", $sformatf("vec%0d flush_d", i), int'(flush_d), int'(TBL[i].fd));
    end

    // R3 and R5: sweep every register number through all four bypass paths
    for (int r = 0; r < (1 << W); r++) begin
      v = '0;
      v.rsd = W'(r); v.rtd = W'(r); v.rse = W'(r); v.rte = W'(r);
      v.dsm = W'(r); v.we_m = 1'b1;
      drive(v);
      chk("R3", $sformatf("reg%0d fwd_a_e", r), int'(fwd_a_e), (r != 0) ? 2 : 0);
      chk("R3", $sformatf("reg%0d fwd_b_e", r), int'(fwd_b_e), (r != 0) ? 2 : 0);
      chk("R5", $sformatf("reg%0d fwd_a_d", r), int'(fwd_a_d), (r != 0) ? 1 : 0);
      chk("R5", $sformatf("reg%0d fwd_b_d", r), int'(fwd_b_d), (r != 0) ? 1 : 0);
    end

    // R3: writeback path also refuses register zero
    v = '0; v.dsw = '0; v.we_w = 1'b1; v.rse = '0; v.rte = '0;
    drive(v);
    chk("R3", "wb zero fwd_a_e", int'(fwd_a_e), 0);

    // R7: memory-stage match that is not a load does not stall the branch
    v = '0; v.rsd = 5'd12; v.rtd = 5'd13; v.dsm = 5'd12; v.we_m = 1'b1; v.br = 1'b1; v.eq = 1'b1;
    v.rse = 5'd1; v.rte = 5'd2; v.dse = 5'd3; v.dsw = 5'd4;
    drive(v);
    check_stall("R7", 1'b0);
    chk("R9", "bypassed taken flush_d", int'(flush_d), 1);

    // R7: same match as a load, on rt_d, stalls and blocks flush_d
    v.dsm = 5'd13; v.ld_m = 1'b1;
    drive(v);
    check_stall("R7", 1'b1);
    chk("R9", "stalled flush_d", int'(flush_d), 0);

    // R6: execute writer without write enable does not stall the branch
    v = '0; v.rsd = 5'd20; v.rtd = 5'd21; v.dse = 5'd20; v.br = 1'b1;
    v.rse = 5'd1; v.rte = 5'd2; v.dsm = 5'd3; v.dsw = 5'd4;
    drive(v);
    check_stall("R6", 1'b0);
    v.we_e = 1'b1;
    drive(v);
    check_stall("R6", 1'b1);

    // R4: load match with the load flag low gives no stall
    v = '0; v.rsd = 5'd9; v.rte = 5'd9; v.rtd = 5'd1; v.rse = 5'd2; v.dse = 5'd9; v.we_e = 1'b1;
    drive(v);
    check_stall("R4", 1'b0);
    v.ld_e = 1'b1;
    drive(v);
    check_stall("R4", 1'b1);

    // R8: load-use and branch hazard together still give one stall
    v.br = 1'b1; v.eq = 1'b1;
    drive(v);
    check_stall("R8", 1'b1);
    chk("R9", "double hazard flush_d", int'(flush_d), 0);

    done = 1'b1;
    summary();
  end

endmodule